// File: doc/BRIEF.md
# Self-Aligning Bit Error Rate Checker

This block receives a serial bit stream that has already been retimed, one bit per cycle in which `in_valid` is high. It compares each bit against a locally generated expectation and counts the mismatches. Before it counts, it must align to the incoming data. In PRBS mode it loads a linear predictor directly from the first received bits. The predictor then runs on its own, using one of six selectable polynomials. In pattern mode it steps through a small stored pattern. After each failed alignment attempt it moves its read position one bit further along.

Alignment is decided by a windowed test. The checker counts errors over a programmed number of bits, and it declares lock when that count stays below a programmed threshold. The same test keeps running after lock, and it drops lock when a window reaches the threshold. While locked, the block counts compared bits and errors until a limit given in 32-bit units is reached. It then either freezes the result (single shot) or starts a new measurement on the next bit (repeat). The error counter saturates and raises a sticky overflow flag.

Top module: `bert_checker`

## Requirements
- R1: While reset is asserted and on release, `sync_locked`, `meas_done`, `err_overflow`, `error_count` and `bits_compared` are all zero.
- R2: In PRBS mode (`cfg_pat_mode`=0), after `enable` rises the first N valid bits load the predictor, where N is the polynomial order. The next W valid bits form the first sync window, where W is `cfg_sync_window`. If that window has fewer errors than `cfg_sync_thresh`, `sync_locked` is high in the cycle after the window's last bit. With a clean stream, lock is seen after exactly N+W bits and not after N+W-1.
- R3: The `cfg_poly` codes select the polynomial as follows: 0 gives PRBS7 with taps (7,6), 1 gives PRBS9 (9,5), 2 gives PRBS11 (11,9), 3 gives PRBS15 (15,14), 4 gives PRBS23 (23,18) and 5 gives PRBS31 (31,28). Any other code gives PRBS7. The predicted bit is b[n] = b[n-a] xor b[n-b]. A stream built from a different polynomial never locks.
- R4: In pattern mode (`cfg_pat_mode`=1), the expected bit is `cfg_pattern[idx]`. The index starts at 0 and advances by one for each valid bit, modulo PAT_LEN. On the last bit of a failing window it advances by two, which slips the alignment by one bit. A stream offset by k bits locks after k failing windows plus one clean window.
- R5: A window, whether searching or locked, fails when its error count, including the window's last bit, is at least `cfg_sync_thresh`. A failure clears lock and restarts the search, re-seeding in PRBS mode. A window with fewer errors keeps lock. Counting pauses while unlocked.
- R6: While locked, each valid bit increments `bits_compared`, and each mismatch increments `error_count`. `meas_done` rises in the cycle after bit number 32*`cfg_meas_words`. With `cfg_repeat`=0 the counters and `meas_done` then stay frozen until `enable` falls.
- R7: With `cfg_repeat`=1, the first counted bit after `meas_done` starts a new measurement. After that bit, `bits_compared` is 1, `error_count` is that bit's mismatch, and `meas_done` and `err_overflow` are 0.
- R8: `error_count` stops at all ones. A mismatch that arrives while it is all ones sets `err_overflow`, which stays set until the counters restart.
- R9: When `enable` is low, the block returns to idle. `sync_locked` is low one cycle later, and the counters, `meas_done` and `err_overflow` are zero one cycle after that. Bits with `in_valid` low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the checker; low returns it to idle |
| in_valid | input | 1 | `in_bit` carries a received bit this cycle |
| in_bit | input | 1 | Received, retimed data bit |
| cfg_pat_mode | input | 1 | 0 = PRBS self-seeding, 1 = stored pattern |
| cfg_poly | input | 3 | Polynomial code (R3) |
| cfg_pattern | input | PAT_LEN | Expected pattern, bit 0 first |
| cfg_sync_thresh | input | SYNC_W | Errors per window that fail the window |
| cfg_sync_window | input | SYNC_W+1 | Bits per sync window |
| cfg_meas_words | input | MEAS_WORD_W | Measurement length in 32-bit units |
| cfg_repeat | input | 1 | 1 = restart after each measurement |
| sync_locked | output | 1 | Alignment held |
| meas_done | output | 1 | Measurement length reached |
| error_count | output | ERR_W | Saturating error count |
| bits_compared | output | MEAS_WORD_W+5 | Bits counted in this measurement |
| err_overflow | output | 1 | An error arrived while the count was saturated |

## Verification
The bench builds the block with PAT_LEN=12, SYNC_W=16, ERR_W=8 and MEAS_WORD_W=6. The 8-bit error counter therefore saturates within a few hundred inverted bits, which makes the overflow path reachable. Windows of 24 and 64 bits make the pattern slips and the PRBS re-seeds short enough to observe. Every polynomial, including the 31st-order one, locks within about a hundred bits. A behavioural model built on queues follows the stream on every clock and is compared against all outputs. Directed checks additionally pin the exact lock cycle, the slip count and the frozen and restarted measurement values.

// File: rtl/bert_pkg.sv
package bert_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEED = 2'd1,
    ST_SYNC = 2'd2,
    ST_LOCK = 2'd3
  } bert_state_e;

  // Longest supported predictor history (PRBS31)
  localparam int HIST_W = 31;

  function automatic logic [4:0] prbs_order(input logic [2:0] sel);
    case (sel)
      3'd1:    return 5'd9;
      3'd2:    return 5'd11;
      3'd3:    return 5'd15;
      3'd4:    return 5'd23;
      3'd5:    return 5'd31;
      default: return 5'd7;
    endcase
  endfunction

  function automatic logic [4:0] prbs_tap(input logic [2:0] sel);
    case (sel)
      3'd1:    return 5'd5;
      3'd2:    return 5'd9;
      3'd3:    return 5'd14;
      3'd4:    return 5'd18;
      3'd5:    return 5'd28;
      default: return 5'd6;
    endcase
  endfunction

  // hist[0] is the newest bit; hist[k-1] is the bit k positions back
  function automatic logic prbs_predict(input logic [HIST_W-1:0] hist,
                                        input logic [2:0] sel);
    logic [4:0] a;
    logic [4:0] b;
    a = prbs_order(sel) - 5'd1;
    b = prbs_tap(sel) - 5'd1;
    return hist[a] ^ hist[b];
  endfunction

endpackage

// File: rtl/bert_expect.sv
module bert_expect
  import bert_pkg::*;
#(
  parameter int PAT_LEN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               seed_shift,
  input  logic               step,
  input  logic               slip,
  input  logic               rx_bit,
  input  logic               pat_mode,
  input  logic [2:0]         poly_sel,
  input  logic [PAT_LEN-1:0] pattern,
  output logic               exp_bit
);
  localparam int IDX_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;

  logic [HIST_W-1:0] hist_q;
  logic [IDX_W-1:0]  idx_q;

  function automatic logic [IDX_W-1:0] idx_advance(input logic [IDX_W-1:0] cur,
                                                   input logic two);
    logic [31:0] s;
    s = 32'(cur) + (two ? 32'd2 : 32'd1);
    if (s >= 32'(PAT_LEN)) s = s - 32'(PAT_LEN);
    return s[IDX_W-1:0];
  endfunction

  always_comb begin
    if (pat_mode) exp_bit = pattern[idx_q];
    else          exp_bit = prbs_predict(hist_q, poly_sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hist_q <= '0;
      idx_q  <= '0;
    end else begin
      if (seed_shift)
        hist_q <= {hist_q[HIST_W-2:0], rx_bit};
      else if (step && !pat_mode)
        hist_q <= {hist_q[HIST_W-2:0], exp_bit};
      if (step && pat_mode)
        idx_q <= idx_advance(idx_q, slip);
    end
  end

endmodule

// File: rtl/bert_sync.sv
module bert_sync
  import bert_pkg::*;
#(
  parameter int SYNC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              pat_mode,
  input  logic [2:0]        poly_sel,
  input  logic              in_valid,
  input  logic              mismatch,
  input  logic [SYNC_W-1:0] sync_thresh,
  input  logic [SYNC_W:0]   sync_window,
  output bert_state_e       state,
  output logic              seed_shift,
  output logic              step,
  output logic              win_fail,
  output logic              win_last
);
  localparam int WIN_W = SYNC_W + 1;

  bert_state_e       nxt;
  logic [4:0]        seed_cnt;
  logic [WIN_W-1:0]  win_cnt;
  logic [SYNC_W-1:0] win_err;
  logic [WIN_W-1:0]  err_now;
  logic              in_window;
  logic              seed_done;

  assign in_window  = (state == ST_SYNC) || (state == ST_LOCK);
  assign step       = in_valid && in_window;
  assign seed_shift = in_valid && (state == ST_SEED);
  assign seed_done  = seed_shift && (seed_cnt == prbs_order(poly_sel) - 5'd1);
  assign err_now    = {1'b0, win_err} + WIN_W'(mismatch);
  assign win_last   = step && ((win_cnt + WIN_W'(1)) == sync_window);
  assign win_fail   = win_last && (err_now >= {1'b0, sync_thresh});

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (enable) nxt = pat_mode ? ST_SYNC : ST_SEED;
      ST_SEED: if (seed_done) nxt = ST_SYNC;
      ST_SYNC: if (win_last) nxt = win_fail ? (pat_mode ? ST_SYNC : ST_SEED) : ST_LOCK;
      ST_LOCK: if (win_fail) nxt = pat_mode ? ST_SYNC : ST_SEED;
      default: nxt = ST_IDLE;
    endcase
    if (!enable) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      seed_cnt <= '0;
      win_cnt  <= '0;
      win_err  <= '0;
    end else begin
      state <= nxt;
      if (state != ST_SEED)  seed_cnt <= '0;
      else if (seed_shift)   seed_cnt <= seed_cnt + 5'd1;
      if (!in_window || win_last) begin
        win_cnt <= '0;
        win_err <= '0;
      end else if (step) begin
        win_cnt <= win_cnt + WIN_W'(1);
        if (mismatch && (win_err != '1)) win_err <= win_err + SYNC_W'(1);
      end
    end
  end

  // R2
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_LOCK) |-> $past(win_last && !win_fail));

  // R5
  lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state == ST_LOCK) |-> ($past(win_fail) || !$past(enable)));

  // R2
  seed_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEED) |-> (seed_cnt < prbs_order(poly_sel)));

endmodule

// File: rtl/bert_meas.sv
module bert_meas #(
  parameter int ERR_W       = 32,
  parameter int MEAS_WORD_W = 29
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   count_en,
  input  logic                   mismatch,
  input  logic [MEAS_WORD_W-1:0] meas_words,
  input  logic                   repeat_mode,
  output logic [ERR_W-1:0]       error_count,
  output logic [MEAS_WORD_W+4:0] bits_compared,
  output logic                   meas_done,
  output logic                   err_overflow
);
  localparam int BITS_W = MEAS_WORD_W + 5;

  logic [BITS_W-1:0] limit;
  logic              restart;
  logic              advance;

  assign limit   = {meas_words, 5'd0};
  assign restart = count_en && meas_done && repeat_mode;
  assign advance = count_en && !meas_done;

  function automatic logic [ERR_W-1:0] err_bump(input logic [ERR_W-1:0] cur,
                                                input logic hit);
    return (hit && (cur != '1)) ? cur + ERR_W'(1) : cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      error_count   <= '0;
      bits_compared <= '0;
      meas_done     <= 1'b0;
      err_overflow  <= 1'b0;
    end else if (restart) begin
      bits_compared <= BITS_W'(1);
      error_count   <= ERR_W'(mismatch);
      meas_done     <= 1'b0;
      err_overflow  <= 1'b0;
    end else if (advance) begin
      bits_compared <= bits_compared + BITS_W'(1);
      error_count   <= err_bump(error_count, mismatch);
      err_overflow  <= err_overflow || (mismatch && (error_count == '1));
      meas_done     <= ((bits_compared + BITS_W'(1)) == limit);
    end
  end

  // R6
  done_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && !clear) |-> (bits_compared == limit));

  // R6
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && !repeat_mode && !clear) |=> $stable(bits_compared) && $stable(error_count));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (bits_compared == BITS_W'(1)) && !meas_done && !err_overflow);

  // R8
  ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> (error_count == '1));

  // R8
  err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !restart) |=> (error_count >= $past(error_count)));

endmodule

// File: rtl/bert_checker.sv
module bert_checker
  import bert_pkg::*;
#(
  parameter int PAT_LEN     = 16,
  parameter int SYNC_W      = 32,
  parameter int ERR_W       = 32,
  parameter int MEAS_WORD_W = 29
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   in_valid,
  input  logic                   in_bit,
  input  logic                   cfg_pat_mode,
  input  logic [2:0]             cfg_poly,
  input  logic [PAT_LEN-1:0]     cfg_pattern,
  input  logic [SYNC_W-1:0]      cfg_sync_thresh,
  input  logic [SYNC_W:0]        cfg_sync_window,
  input  logic [MEAS_WORD_W-1:0] cfg_meas_words,
  input  logic                   cfg_repeat,
  output logic                   sync_locked,
  output logic                   meas_done,
  output logic [ERR_W-1:0]       error_count,
  output logic [MEAS_WORD_W+4:0] bits_compared,
  output logic                   err_overflow
);
  bert_state_e state;
  logic        exp_bit;
  logic        mismatch;
  logic        seed_shift;
  logic        step;
  logic        win_fail;
  logic        win_last;
  logic        clear;
  logic        count_en;

  assign mismatch    = in_valid && (in_bit != exp_bit);
  assign clear       = (state == ST_IDLE);
  assign count_en    = in_valid && (state == ST_LOCK);
  assign sync_locked = (state == ST_LOCK);

  bert_sync #(.SYNC_W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pat_mode(cfg_pat_mode),
    .poly_sel(cfg_poly), .in_valid(in_valid), .mismatch(mismatch),
    .sync_thresh(cfg_sync_thresh), .sync_window(cfg_sync_window),
    .state(state), .seed_shift(seed_shift), .step(step),
    .win_fail(win_fail), .win_last(win_last)
  );

  bert_expect #(.PAT_LEN(PAT_LEN)) u_expect (
    .clk(clk), .rst_n(rst_n), .clear(clear), .seed_shift(seed_shift),
    .step(step), .slip(win_fail), .rx_bit(in_bit), .pat_mode(cfg_pat_mode),
    .poly_sel(cfg_poly), .pattern(cfg_pattern), .exp_bit(exp_bit)
  );

  bert_meas #(.ERR_W(ERR_W), .MEAS_WORD_W(MEAS_WORD_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .clear(clear), .count_en(count_en),
    .mismatch(mismatch), .meas_words(cfg_meas_words), .repeat_mode(cfg_repeat),
    .error_count(error_count), .bits_compared(bits_compared),
    .meas_done(meas_done), .err_overflow(err_overflow)
  );

  // R2
  lock_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_locked) |-> $past(in_valid));

  // R9
  idle_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> !sync_locked);

  // R6
  count_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_compared != $past(bits_compared)) |-> ($past(sync_locked && in_valid) || $past(clear)));

endmodule

// File: tb/bert_checker_tb.sv
module bert_checker_tb;
  localparam int PL = 12;
  localparam int SW = 16;
  localparam int EW = 8;
  localparam int MW = 6;
  localparam longint ERRMAX = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic cfg_pat_mode = 1'b0;
  logic [2:0] cfg_poly = 3'd0;
  logic [PL-1:0] cfg_pattern = '0;
  logic [SW-1:0] cfg_sync_thresh = SW'(4);
  logic [SW:0] cfg_sync_window = (SW+1)'(64);
  logic [MW-1:0] cfg_meas_words = MW'(4);
  logic cfg_repeat = 1'b0;
  logic sync_locked, meas_done, err_overflow;
  logic [EW-1:0] error_count;
  logic [MW+4:0] bits_compared;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bert_checker #(.PAT_LEN(PL), .SYNC_W(SW), .ERR_W(EW), .MEAS_WORD_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid), .in_bit(in_bit),
    .cfg_pat_mode(cfg_pat_mode), .cfg_poly(cfg_poly), .cfg_pattern(cfg_pattern),
    .cfg_sync_thresh(cfg_sync_thresh), .cfg_sync_window(cfg_sync_window),
    .cfg_meas_words(cfg_meas_words), .cfg_repeat(cfg_repeat),
    .sync_locked(sync_locked), .meas_done(meas_done), .error_count(error_count),
    .bits_compared(bits_compared), .err_overflow(err_overflow)
  );

  function automatic int ord_of(input int sel);
    int t[6] = '{7, 9, 11, 15, 23, 31};
    return (sel < 6) ? t[sel] : 7;
  endfunction
  function automatic int tap_of(input int sel);
    int t[6] = '{6, 5, 9, 14, 18, 28};
    return (sel < 6) ? t[sel] : 6;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_state, m_seed, m_idx;
  bit m_hist[$];
  longint m_wcnt, m_werr, m_bits, m_errs;
  bit m_done, m_ovf;
  bit e_bit, mm, fail;
  int nxt;

  task automatic model_clear_hist();
    m_hist = {};
    repeat (31) m_hist.push_front(1'b0);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_seed = 0; m_idx = 0; m_wcnt = 0; m_werr = 0;
      m_bits = 0; m_errs = 0; m_done = 0; m_ovf = 0;
      model_clear_hist();
    end else begin
      nxt = m_state;
      if (cfg_pat_mode) e_bit = cfg_pattern[m_idx];
      else e_bit = m_hist[ord_of(cfg_poly)-1] ^ m_hist[tap_of(cfg_poly)-1];
      mm = in_valid && (in_bit != e_bit);
      // measurement
      if (m_state == 0) begin
        m_bits = 0; m_errs = 0; m_done = 0; m_ovf = 0;
      end else if (in_valid && m_state == 3) begin
        if (m_done) begin
          if (cfg_repeat) begin m_bits = 1; m_errs = mm; m_done = 0; m_ovf = 0; end
        end else begin
          m_bits++;
          if (mm) begin
            if (m_errs == ERRMAX) m_ovf = 1; else m_errs++;
          end
          m_done = (m_bits == longint'(cfg_meas_words) * 32);
        end
      end
      // alignment
      if (m_state != 1) m_seed = 0;
      case (m_state)
        0: begin
          model_clear_hist(); m_idx = 0; m_wcnt = 0; m_werr = 0;
          if (enable) nxt = cfg_pat_mode ? 2 : 1;
        end
        1: if (in_valid) begin
          m_hist.push_front(in_bit); void'(m_hist.pop_back());
          m_seed++;
          if (m_seed == ord_of(cfg_poly)) nxt = 2;
        end
        default: if (in_valid) begin
          m_wcnt++;
          if (mm) m_werr++;
          fail = 0;
          if (m_wcnt == longint'(cfg_sync_window)) begin
            fail = (m_werr >= longint'(cfg_sync_thresh));
            m_wcnt = 0; m_werr = 0;
            if (fail) nxt = cfg_pat_mode ? 2 : 1;
            else if (m_state == 2) nxt = 3;
          end
          if (cfg_pat_mode) m_idx = (m_idx + (fail ? 2 : 1)) % PL;
          else begin m_hist.push_front(e_bit); void'(m_hist.pop_back()); end
        end
      endcase
      if (!enable) nxt = 0;
      m_state = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R5", "model sync_locked", sync_locked, (m_state == 3));
      check("R6", "model meas_done", meas_done, m_done);
      check("R6", "model bits_compared", bits_compared, m_bits);
      check("R8", "model error_count", error_count, m_errs);
      check("R8", "model err_overflow", err_overflow, m_ovf);
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [30:0] g;
  int g_sel;

  task automatic gen_bit(output bit b);
    b = g[ord_of(g_sel)-1] ^ g[tap_of(g_sel)-1];
    g = {g[29:0], b};
  endtask

  task automatic send(input bit b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_prbs(input int n, input bit flip);
    bit b;
    for (int i = 0; i < n; i++) begin
      gen_bit(b);
      send(b ^ flip);
    end
  endtask

  task automatic start_run();
    @(negedge clk);
    enable = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic stop_run();
    @(negedge clk);
    enable = 1'b0;
    in_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired (R1) actual=0 expected=1");
    finish_run();
  end

  localparam logic [PL-1:0] PAT = 12'b100111010110;

  initial begin
    bit b;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "sync_locked", sync_locked, 0);
    check("R1", "meas_done", meas_done, 0);
    check("R1", "error_count", error_count, 0);
    check("R1", "bits_compared", bits_compared, 0);
    check("R1", "err_overflow", err_overflow, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // PRBS7 single shot with two injected errors
    g_sel = 0; g = '1; cfg_poly = 3'd0; cfg_pat_mode = 0;
    cfg_sync_thresh = SW'(4); cfg_sync_window = (SW+1)'(64);
    cfg_meas_words = MW'(4); cfg_repeat = 0;
    start_run();
    send_prbs(70, 0);
    check("R2", "locked before N+W", sync_locked, 0);
    send_prbs(1, 0);
    check("R2", "locked at N+W", sync_locked, 1);
    for (int i = 0; i < 128; i++) begin
      gen_bit(b);
      send(b ^ ((i == 10) || (i == 20)));
    end
    check("R6", "done after 128", meas_done, 1);
    check("R6", "bits after 128", bits_compared, 128);
    check("R6", "errors after 128", error_count, 2);
    check("R5", "lock kept below threshold", sync_locked, 1);
    send_prbs(30, 0);
    check("R6", "frozen bits", bits_compared, 128);
    check("R6", "frozen done", meas_done, 1);
    send_prbs(128, 1);
    check("R5", "lock lost on errors", sync_locked, 0);
    check("R5", "count paused", bits_compared, 128);
    stop_run();
    check("R9", "idle locked", sync_locked, 0);
    check("R9", "idle bits", bits_compared, 0);
    check("R9", "idle errors", error_count, 0);
    check("R9", "idle done", meas_done, 0);

    // pattern mode, offset 3, repeat
    cfg_pat_mode = 1; cfg_pattern = PAT;
    cfg_sync_thresh = SW'(3); cfg_sync_window = (SW+1)'(24);
    cfg_meas_words = MW'(4); cfg_repeat = 1;
    start_run();
    for (int j = 0; j < 95; j++) send(PAT[(j + 3) % PL]);
    check("R4", "no lock before 3 slips + window", sync_locked, 0);
    send(PAT[(95 + 3) % PL]);
    check("R4", "locked after 3 slips + window", sync_locked, 1);
    for (int j = 96; j < 96 + 128; j++) send(PAT[(j + 3) % PL]);
    check("R6", "pattern done", meas_done, 1);
    check("R6", "pattern bits", bits_compared, 128);
    check("R6", "pattern errors", error_count, 0);
    send(PAT[(224 + 3) % PL]);
    check("R7", "restart bits", bits_compared, 1);
    check("R7", "restart done", meas_done, 0);
    // a gap in valid must not count (R9)
    repeat (5) @(posedge clk);
    #1;
    check("R9", "valid low ignored", bits_compared, 1);
    stop_run();

    // PRBS15 saturation
    cfg_pat_mode = 0; cfg_poly = 3'd3; g_sel = 3; g = '1;
    cfg_sync_thresh = SW'(65); cfg_sync_window = (SW+1)'(64);
    cfg_meas_words = MW'(10); cfg_repeat = 0;
    start_run();
    send_prbs(79, 0);
    check("R3", "PRBS15 lock", sync_locked, 1);
    send_prbs(300, 1);
    check("R8", "saturated count", error_count, ERRMAX);
    check("R8", "overflow flag", err_overflow, 1);
    check("R8", "bits during saturation", bits_compared, 300);
    stop_run();
    check("R9", "overflow cleared", err_overflow, 0);

    // every polynomial code
    cfg_sync_thresh = SW'(4); cfg_meas_words = MW'(4);
    for (int s = 0; s < 6; s++) begin
      cfg_poly = 3'(s); g_sel = s; g = '1;
      start_run();
      send_prbs(ord_of(s) + 63, 0);
      check("R3", $sformatf("code %0d early", s), sync_locked, 0);
      send_prbs(1, 0);
      check("R3", $sformatf("code %0d lock", s), sync_locked, 1);
      stop_run();
    end

    // wrong polynomial never locks
    cfg_poly = 3'd0; g_sel = 1; g = '1;
    start_run();
    send_prbs(300, 0);
    check("R3", "mismatched polynomial", sync_locked, 0);
    stop_run();

    finish_run();
  end

endmodule